// File: doc/BRIEF.md
# Adjacent Instruction Fusion Detector

This block sits in the decode stage of a 64-bit RISC-V core. Each cycle it looks at two neighbouring 32-bit instruction words, an older one and a younger one, each with its own valid flag. It decides whether the two form one of six known idioms that a back end can run as a single operation. When a pair qualifies, the block reports a kind code and the architectural register that the fused operation writes.

The six idioms are:

- building a constant with an upper-immediate load followed by an add-immediate;
- forming a PC-relative address;
- two shift-pair zero-extensions, one for 16-bit values and one for 32-bit values;
- a shifted 32-bit zero-extension;
- a register-indexed load made from an add followed by a zero-offset doubleword load.

Software or a tuning strap drives a six-bit mask that switches each idiom on or off. When more than one enabled idiom matches, the lowest kind code wins. The result is registered, so a pair sampled at one clock edge shows up on the outputs after that edge.

Top module: `fuse_pair_detector`

## Requirements
- R1: An older LUI (opcode 0110111) followed by a younger ADDI (opcode 0010011, funct3 000) or ADDIW (opcode 0011011, funct3 000) reports kind 1.
- R2: An older AUIPC (opcode 0010111) followed by a younger ADDI reports kind 2. AUIPC followed by ADDIW is not fused.
- R3: SLLI with shamt 48 (opcode 0010011, funct3 001, bits [31:26] zero, shamt in bits [25:20]) followed by SRLI with shamt 48 (funct3 101, bits [31:26] zero) reports kind 3. Any other shift amount, or SRAI (bits [31:26] = 010000), is not fused as kind 3.
- R4: SLLI by 32 followed by SRLI by 32 reports kind 4.
- R5: SLLI by 32 followed by SRLI by any amount from 0 to 31 reports kind 5. An SRLI by 32 or more never yields kind 5.
- R6: An older ADD (opcode 0110011, funct3 000, funct7 0) followed by a younger LD (opcode 0000011, funct3 011) whose 12-bit offset in bits [31:20] is zero reports kind 6. A nonzero offset is not fused.
- R7: A pair fuses only when the older rd (bits [11:7]), the younger rd and the younger rs1 (bits [19:15]) are the same register. That register is reported on fuse_rd.
- R8: No fusion is reported when either valid input is low, or when the shared register is x0.
- R9: Bit k-1 of kind_enable enables kind k. A kind whose bit is clear is never reported.
- R10: Outputs change one clock edge after the inputs are sampled. During reset, and whenever no pair fuses, fuse_valid, fuse_kind and fuse_rd are all zero.
- R11: fuse_valid is high exactly when fuse_kind is nonzero, and fuse_kind never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_enable | input | 6 | Per-kind enable, bit k-1 for kind k |
| older_valid | input | 1 | Older slot holds an instruction |
| older_insn | input | 32 | Older instruction word |
| younger_valid | input | 1 | Younger slot holds an instruction |
| younger_insn | input | 32 | Younger instruction word |
| fuse_valid | output | 1 | A fusible pair was found |
| fuse_kind | output | 3 | Kind code, 0 when none |
| fuse_rd | output | 5 | Destination register of the fused pair, 0 when none |

## Verification
The only internal state is the output register. A corrupted decode flag or a corrupted match term is therefore visible at the ports in the very next cycle, as a wrong or missing kind code. Errors on the boundaries are the likely failures: shift amounts of 31, 32 and 48, a load offset of zero against a nonzero one, and a mismatch in one register field. The bench drives each of these and samples one edge later. A broken priority order or a broken enable gate shows up the same way, because kind 4 and kind 5 share their older instruction and differ only in the younger shift amount.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_W     = 5;
  localparam int SHAMT_W   = 6;
  localparam int NUM_KINDS = 6;
  localparam int KIND_W    = $clog2(NUM_KINDS + 1);
  localparam int IMM_W     = 12;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE       = 3'd0,
    FK_LUI_ADDI   = 3'd1,
    FK_AUIPC_ADDI = 3'd2,
    FK_ZEXT_HALF  = 3'd3,
    FK_ZEXT_WORD  = 3'd4,
    FK_ZEXT_WSHR  = 3'd5,
    FK_ADD_LOAD   = 3'd6
  } fuse_kind_e;

  typedef struct packed {
    logic               is_lui;
    logic               is_auipc;
    logic               is_addi;
    logic               is_addiw;
    logic               is_slli;
    logic               is_srli;
    logic               is_add;
    logic               is_ld;
    logic               imm_zero;
    logic [SHAMT_W-1:0] shamt;
    logic [REG_W-1:0]   rd;
    logic [REG_W-1:0]   rs1;
  } insn_info_t;
endpackage

// File: rtl/insn_field_decode.sv
module insn_field_decode
  import fuse_pkg::*;
#(
  parameter int P_INSN_W  = INSN_W,
  parameter int P_SHAMT_W = SHAMT_W,
  parameter int P_IMM_W   = IMM_W
) (
  input  logic [P_INSN_W-1:0] insn,
  output insn_info_t          info
);
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPIMMW = 7'b0011011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam int SHAMT_LO  = 20;
  localparam int FUNCT6_LO = SHAMT_LO + P_SHAMT_W;
  localparam int FUNCT6_W  = P_INSN_W - FUNCT6_LO;
  localparam int IMM_LO    = P_INSN_W - P_IMM_W;

  logic [6:0]          opcode;
  logic [2:0]          funct3;
  logic [6:0]          funct7;
  logic [FUNCT6_W-1:0] funct6;

  always_comb begin
    opcode = insn[6:0];
    funct3 = insn[14:12];
    funct7 = insn[31:25];
    funct6 = insn[P_INSN_W-1:FUNCT6_LO];

    info          = '0;
    info.rd       = insn[11:7];
    info.rs1      = insn[19:15];
    info.shamt    = insn[FUNCT6_LO-1:SHAMT_LO];
    info.imm_zero = (insn[P_INSN_W-1:IMM_LO] == '0);
    info.is_lui   = (opcode == OPC_LUI);
    info.is_auipc = (opcode == OPC_AUIPC);
    info.is_addi  = (opcode == OPC_OPIMM)  && (funct3 == 3'b000);
    info.is_addiw = (opcode == OPC_OPIMMW) && (funct3 == 3'b000);
    info.is_slli  = (opcode == OPC_OPIMM)  && (funct3 == 3'b001) && (funct6 == '0);
    info.is_srli  = (opcode == OPC_OPIMM)  && (funct3 == 3'b101) && (funct6 == '0);
    info.is_add   = (opcode == OPC_OP)     && (funct3 == 3'b000) && (funct7 == 7'b0);
    info.is_ld    = (opcode == OPC_LOAD)   && (funct3 == 3'b011);
  end
endmodule

// File: rtl/fuse_kind_match.sv
module fuse_kind_match
  import fuse_pkg::*;
#(
  parameter int P_NUM_KINDS = NUM_KINDS,
  parameter int P_SHAMT_W   = SHAMT_W,
  parameter int SHAMT_HALF  = 48,
  parameter int SHAMT_WORD  = 32
) (
  input  insn_info_t             older,
  input  insn_info_t             younger,
  input  logic                   older_valid,
  input  logic                   younger_valid,
  input  logic [P_NUM_KINDS-1:0] kind_enable,
  output logic [P_NUM_KINDS-1:0] hit
);
  localparam logic [P_SHAMT_W-1:0] SH_HALF = P_SHAMT_W'(SHAMT_HALF);
  localparam logic [P_SHAMT_W-1:0] SH_WORD = P_SHAMT_W'(SHAMT_WORD);

  logic                   link_ok;
  logic [P_NUM_KINDS-1:0] raw;

  always_comb begin
    link_ok = older_valid && younger_valid
           && (older.rd != '0)
           && (younger.rd  == older.rd)
           && (younger.rs1 == older.rd);

    raw = '0;
    raw[0] = older.is_lui   && (younger.is_addi || younger.is_addiw);
    raw[1] = older.is_auipc && younger.is_addi;
    raw[2] = older.is_slli  && (older.shamt == SH_HALF)
          && younger.is_srli && (younger.shamt == SH_HALF);
    raw[3] = older.is_slli  && (older.shamt == SH_WORD)
          && younger.is_srli && (younger.shamt == SH_WORD);
    raw[4] = older.is_slli  && (older.shamt == SH_WORD)
          && younger.is_srli && (younger.shamt < SH_WORD);
    raw[5] = older.is_add   && younger.is_ld && younger.imm_zero;
  end

  for (genvar k = 0; k < P_NUM_KINDS; k++) begin : g_gate
    assign hit[k] = raw[k] && kind_enable[k] && link_ok;
  end
endmodule

// File: rtl/fuse_priority_pick.sv
module fuse_priority_pick #(
  parameter int P_NUM_KINDS = 6,
  parameter int P_KIND_W    = $clog2(P_NUM_KINDS + 1)
) (
  input  logic [P_NUM_KINDS-1:0] hit,
  output logic                   any,
  output logic [P_KIND_W-1:0]    kind
);
  always_comb begin
    any  = |hit;
    kind = '0;
    for (int i = P_NUM_KINDS - 1; i >= 0; i--) begin
      if (hit[i]) kind = P_KIND_W'(i + 1);
    end
  end
endmodule

// File: rtl/fuse_pair_detector.sv
module fuse_pair_detector
  import fuse_pkg::*;
#(
  parameter int P_INSN_W    = INSN_W,
  parameter int P_REG_W     = REG_W,
  parameter int P_NUM_KINDS = NUM_KINDS,
  parameter int P_KIND_W    = KIND_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [P_NUM_KINDS-1:0] kind_enable,
  input  logic                   older_valid,
  input  logic [P_INSN_W-1:0]    older_insn,
  input  logic                   younger_valid,
  input  logic [P_INSN_W-1:0]    younger_insn,
  output logic                   fuse_valid,
  output logic [P_KIND_W-1:0]    fuse_kind,
  output logic [P_REG_W-1:0]     fuse_rd
);
  localparam int SLOTS = 2;

  logic [P_INSN_W-1:0]    slot_insn [SLOTS];
  insn_info_t             slot_info [SLOTS];
  logic [P_NUM_KINDS-1:0] hit;
  logic                   any_hit;
  logic [P_KIND_W-1:0]    pick_kind;

  assign slot_insn[0] = older_insn;
  assign slot_insn[1] = younger_insn;

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    insn_field_decode #(.P_INSN_W(P_INSN_W)) u_dec (
      .insn (slot_insn[s]),
      .info (slot_info[s])
    );
  end

  fuse_kind_match #(.P_NUM_KINDS(P_NUM_KINDS)) u_match (
    .older         (slot_info[0]),
    .younger       (slot_info[1]),
    .older_valid   (older_valid),
    .younger_valid (younger_valid),
    .kind_enable   (kind_enable),
    .hit           (hit)
  );

  fuse_priority_pick #(.P_NUM_KINDS(P_NUM_KINDS), .P_KIND_W(P_KIND_W)) u_pick (
    .hit  (hit),
    .any  (any_hit),
    .kind (pick_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fuse_valid <= 1'b0;
      fuse_kind  <= '0;
      fuse_rd    <= '0;
    end else begin
      fuse_valid <= any_hit;
      fuse_kind  <= pick_kind;
      fuse_rd    <= any_hit ? slot_info[0].rd : '0;
    end
  end
endmodule

// File: rtl/fuse_pair_detector_chk.sv
module fuse_pair_detector_chk #(
  parameter int P_INSN_W    = 32,
  parameter int P_REG_W     = 5,
  parameter int P_NUM_KINDS = 6,
  parameter int P_KIND_W    = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [P_NUM_KINDS-1:0] kind_enable,
  input logic                   older_valid,
  input logic [P_INSN_W-1:0]    older_insn,
  input logic                   younger_valid,
  input logic [P_INSN_W-1:0]    younger_insn,
  input logic                   fuse_valid,
  input logic [P_KIND_W-1:0]    fuse_kind,
  input logic [P_REG_W-1:0]     fuse_rd
);
  logic [P_NUM_KINDS-1:0] en_q;
  logic                   en_hit;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= kind_enable;
  end

  always_comb begin
    en_hit = 1'b0;
    for (int k = 0; k < P_NUM_KINDS; k++) begin
      if (fuse_kind == P_KIND_W'(k + 1) && en_q[k]) en_hit = 1'b1;
    end
  end

  assert_valid_kind_agree_R11: assert property (@(posedge clk) disable iff (rst)
    fuse_valid == (fuse_kind != '0));

  assert_kind_in_range_R11: assert property (@(posedge clk) disable iff (rst)
    fuse_kind <= P_KIND_W'(P_NUM_KINDS));

  assert_invalid_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (!older_valid || !younger_valid) |=> !fuse_valid);

  assert_no_x0_R8: assert property (@(posedge clk) disable iff (rst)
    fuse_valid |-> fuse_rd != '0);

  assert_reg_link_R7: assert property (@(posedge clk) disable iff (rst)
    fuse_valid |-> (fuse_rd == $past(older_insn[11:7])
                 && fuse_rd == $past(younger_insn[11:7])
                 && fuse_rd == $past(younger_insn[19:15])));

  assert_enable_gate_R9: assert property (@(posedge clk) disable iff (rst)
    fuse_valid |-> en_hit);

  assert_idle_rd_R10: assert property (@(posedge clk) disable iff (rst)
    !fuse_valid |-> fuse_rd == '0);
endmodule

bind fuse_pair_detector fuse_pair_detector_chk #(
  .P_INSN_W(P_INSN_W), .P_REG_W(P_REG_W),
  .P_NUM_KINDS(P_NUM_KINDS), .P_KIND_W(P_KIND_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .kind_enable   (kind_enable),
  .older_valid   (older_valid),
  .older_insn    (older_insn),
  .younger_valid (younger_valid),
  .younger_insn  (younger_insn),
  .fuse_valid    (fuse_valid),
  .fuse_kind     (fuse_kind),
  .fuse_rd       (fuse_rd)
);

// File: tb/fuse_pair_detector_test.sv
module fuse_pair_detector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  kind_enable = '0;
  logic        older_valid = 1'b0;
  logic [31:0] older_insn = '0;
  logic        younger_valid = 1'b0;
  logic [31:0] younger_insn = '0;
  logic        fuse_valid;
  logic [2:0]  fuse_kind;
  logic [4:0]  fuse_rd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fuse_pair_detector uut (
    .clk(clk), .rst(rst), .kind_enable(kind_enable),
    .older_valid(older_valid), .older_insn(older_insn),
    .younger_valid(younger_valid), .younger_insn(younger_insn),
    .fuse_valid(fuse_valid), .fuse_kind(fuse_kind), .fuse_rd(fuse_rd)
  );

  function automatic logic [31:0] enc_u(logic [6:0] op, logic [4:0] rd, logic [19:0] imm);
    return {imm, rd, op};
  endfunction
  function automatic logic [31:0] enc_i(logic [6:0] op, logic [2:0] f3, logic [4:0] rd,
                                        logic [4:0] rs1, logic [11:0] imm);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] lui(logic [4:0] rd, logic [19:0] imm);
    return enc_u(7'b0110111, rd, imm);
  endfunction
  function automatic logic [31:0] auipc(logic [4:0] rd, logic [19:0] imm);
    return enc_u(7'b0010111, rd, imm);
  endfunction
  function automatic logic [31:0] addi(logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
    return enc_i(7'b0010011, 3'b000, rd, rs1, imm);
  endfunction
  function automatic logic [31:0] addiw(logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
    return enc_i(7'b0011011, 3'b000, rd, rs1, imm);
  endfunction
  function automatic logic [31:0] slli(logic [4:0] rd, logic [4:0] rs1, logic [5:0] sh);
    return enc_i(7'b0010011, 3'b001, rd, rs1, {6'b000000, sh});
  endfunction
  function automatic logic [31:0] srli(logic [4:0] rd, logic [4:0] rs1, logic [5:0] sh);
    return enc_i(7'b0010011, 3'b101, rd, rs1, {6'b000000, sh});
  endfunction
  function automatic logic [31:0] srai(logic [4:0] rd, logic [4:0] rs1, logic [5:0] sh);
    return enc_i(7'b0010011, 3'b101, rd, rs1, {6'b010000, sh});
  endfunction
  function automatic logic [31:0] add(logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {7'b0, rs2, rs1, 3'b000, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] ld(logic [4:0] rd, logic [4:0] rs1, logic [11:0] off);
    return enc_i(7'b0000011, 3'b011, rd, rs1, off);
  endfunction

  task automatic check(input logic [2:0] ek, input logic [4:0] erd, input string req);
    logic ev;
    ev = (ek != 3'd0);
    total++;
    if (fuse_valid !== ev || fuse_kind !== ek || fuse_rd !== erd) begin
      bad++;
      $display("FAIL %s: got valid=%0b kind=%0d rd=%0d, expected valid=%0b kind=%0d rd=%0d",
               req, fuse_valid, fuse_kind, fuse_rd, ev, ek, erd);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge,
  // sample at the falling edge after that
  task automatic run_pair(input logic ov, input logic [31:0] oi, input logic yv,
                          input logic [31:0] yi, input logic [5:0] en,
                          input logic [2:0] ek, input logic [4:0] erd, input string req);
    @(negedge clk);
    older_valid = ov; older_insn = oi;
    younger_valid = yv; younger_insn = yi;
    kind_enable = en;
    @(negedge clk);
    check(ek, erd, req);
  endtask

  task automatic test_reset;
    older_valid = 1'b1; older_insn = lui(5'd5, 20'h12345);
    younger_valid = 1'b1; younger_insn = addi(5'd5, 5'd5, 12'h678);
    kind_enable = 6'h3F;
    repeat (3) @(negedge clk);
    check(3'd0, 5'd0, "R10 reset");
    rst = 1'b0;
    @(negedge clk);
    check(3'd1, 5'd5, "R10 first cycle after reset");
  endtask

  task automatic test_lui_addi;
    run_pair(1, lui(5'd10, 20'hABCDE), 1, addi(5'd10, 5'd10, 12'h123), 6'h3F, 3'd1, 5'd10, "R1 lui+addi");
    run_pair(1, lui(5'd11, 20'h00001), 1, addiw(5'd11, 5'd11, 12'hFFF), 6'h3F, 3'd1, 5'd11, "R1 lui+addiw");
    run_pair(1, lui(5'd10, 20'hABCDE), 1, addi(5'd12, 5'd10, 12'h1), 6'h3F, 3'd0, 5'd0, "R7 lui+addi rd mismatch");
    run_pair(1, lui(5'd10, 20'hABCDE), 1, addi(5'd10, 5'd9, 12'h1), 6'h3F, 3'd0, 5'd0, "R7 lui+addi rs1 mismatch");
  endtask

  task automatic test_auipc_addi;
    run_pair(1, auipc(5'd3, 20'h00010), 1, addi(5'd3, 5'd3, 12'h040), 6'h3F, 3'd2, 5'd3, "R2 auipc+addi");
    run_pair(1, auipc(5'd3, 20'h00010), 1, addiw(5'd3, 5'd3, 12'h040), 6'h3F, 3'd0, 5'd0, "R2 auipc+addiw rejected");
    run_pair(1, auipc(5'd3, 20'h00010), 1, addi(5'd4, 5'd3, 12'h040), 6'h3F, 3'd0, 5'd0, "R7 auipc+addi rd mismatch");
  endtask

  task automatic test_zext_half;
    run_pair(1, slli(5'd8, 5'd20, 6'd48), 1, srli(5'd8, 5'd8, 6'd48), 6'h3F, 3'd3, 5'd8, "R3 slli48+srli48");
    run_pair(1, slli(5'd8, 5'd20, 6'd48), 1, srai(5'd8, 5'd8, 6'd48), 6'h3F, 3'd0, 5'd0, "R3 srai rejected");
    run_pair(1, slli(5'd8, 5'd20, 6'd47), 1, srli(5'd8, 5'd8, 6'd48), 6'h3F, 3'd0, 5'd0, "R3 slli47 rejected");
    run_pair(1, slli(5'd8, 5'd20, 6'd48), 1, srli(5'd8, 5'd8, 6'd32), 6'h3F, 3'd0, 5'd0, "R3 slli48+srli32 rejected");
    run_pair(1, slli(5'd8, 5'd20, 6'd48), 1, srli(5'd8, 5'd9, 6'd48), 6'h3F, 3'd0, 5'd0, "R7 zext-h rs1 mismatch");
  endtask

  task automatic test_zext_word;
    run_pair(1, slli(5'd14, 5'd2, 6'd32), 1, srli(5'd14, 5'd14, 6'd32), 6'h3F, 3'd4, 5'd14, "R4 slli32+srli32");
    run_pair(1, slli(5'd14, 5'd2, 6'd32), 1, srli(5'd15, 5'd14, 6'd32), 6'h3F, 3'd0, 5'd0, "R7 zext-w rd mismatch");
    run_pair(1, slli(5'd14, 5'd2, 6'd32), 1, srli(5'd14, 5'd14, 6'd32), 6'h37, 3'd0, 5'd0, "R5 srli32 never kind5");
  endtask

  task automatic test_zext_shifted;
    run_pair(1, slli(5'd21, 5'd1, 6'd32), 1, srli(5'd21, 5'd21, 6'd31), 6'h3F, 3'd5, 5'd21, "R5 srli31");
    run_pair(1, slli(5'd21, 5'd1, 6'd32), 1, srli(5'd21, 5'd21, 6'd0), 6'h3F, 3'd5, 5'd21, "R5 srli0");
    run_pair(1, slli(5'd21, 5'd1, 6'd32), 1, srli(5'd21, 5'd21, 6'd33), 6'h3F, 3'd0, 5'd0, "R5 srli33 rejected");
    run_pair(1, slli(5'd21, 5'd1, 6'd31), 1, srli(5'd21, 5'd21, 6'd31), 6'h3F, 3'd0, 5'd0, "R5 slli31 rejected");
    run_pair(1, slli(5'd21, 5'd1, 6'd32), 1, srai(5'd21, 5'd21, 6'd16), 6'h3F, 3'd0, 5'd0, "R5 srai rejected");
    run_pair(1, slli(5'd21, 5'd1, 6'd32), 1, srli(5'd21, 5'd22, 6'd16), 6'h3F, 3'd0, 5'd0, "R7 shifted zext rs1 mismatch");
  endtask

  task automatic test_add_load;
    run_pair(1, add(5'd7, 5'd3, 5'd4), 1, ld(5'd7, 5'd7, 12'h000), 6'h3F, 3'd6, 5'd7, "R6 add+ld offset 0");
    run_pair(1, add(5'd7, 5'd3, 5'd4), 1, ld(5'd7, 5'd7, 12'h008), 6'h3F, 3'd0, 5'd0, "R6 ld offset 8 rejected");
    run_pair(1, add(5'd7, 5'd3, 5'd4), 1, ld(5'd7, 5'd7, 12'hFF8), 6'h3F, 3'd0, 5'd0, "R6 ld offset -8 rejected");
    run_pair(1, add(5'd7, 5'd3, 5'd4), 1, ld(5'd6, 5'd7, 12'h000), 6'h3F, 3'd0, 5'd0, "R7 add+ld rd mismatch");
  endtask

  task automatic test_valid_and_x0;
    run_pair(0, lui(5'd9, 20'h1), 1, addi(5'd9, 5'd9, 12'h1), 6'h3F, 3'd0, 5'd0, "R8 older invalid");
    run_pair(1, lui(5'd9, 20'h1), 0, addi(5'd9, 5'd9, 12'h1), 6'h3F, 3'd0, 5'd0, "R8 younger invalid");
    run_pair(1, lui(5'd0, 20'h1), 1, addi(5'd0, 5'd0, 12'h1), 6'h3F, 3'd0, 5'd0, "R8 x0 destination");
    run_pair(1, lui(5'd31, 20'h1), 1, addi(5'd31, 5'd31, 12'h1), 6'h3F, 3'd1, 5'd31, "R10 fuse after idle");
    run_pair(1, add(5'd2, 5'd3, 5'd4), 1, addi(5'd2, 5'd2, 12'h1), 6'h3F, 3'd0, 5'd0, "R10 idle outputs zero");
  endtask

  task automatic test_enable;
    logic [31:0] o_i [6];
    logic [31:0] y_i [6];
    o_i[0] = lui(5'd13, 20'h5);               y_i[0] = addi(5'd13, 5'd13, 12'h5);
    o_i[1] = auipc(5'd13, 20'h5);             y_i[1] = addi(5'd13, 5'd13, 12'h5);
    o_i[2] = slli(5'd13, 5'd1, 6'd48);        y_i[2] = srli(5'd13, 5'd13, 6'd48);
    o_i[3] = slli(5'd13, 5'd1, 6'd32);        y_i[3] = srli(5'd13, 5'd13, 6'd32);
    o_i[4] = slli(5'd13, 5'd1, 6'd32);        y_i[4] = srli(5'd13, 5'd13, 6'd5);
    o_i[5] = add(5'd13, 5'd1, 5'd2);          y_i[5] = ld(5'd13, 5'd13, 12'h0);
    for (int k = 0; k < 6; k++) begin
      run_pair(1, o_i[k], 1, y_i[k], 6'h3F & ~(6'd1 << k), 3'd0, 5'd0, "R9 kind disabled");
      run_pair(1, o_i[k], 1, y_i[k], 6'd1 << k, 3'(k + 1), 5'd13, "R9 only this kind enabled");
    end
  endtask

  initial begin
    test_reset();
    test_lui_addi();
    test_auipc_addi();
    test_zext_half();
    test_zext_word();
    test_zext_shifted();
    test_add_load();
    test_valid_and_x0();
    test_enable();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule